// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a watchdog timer for a processor subsystem. Software starts it by writing one exact 32-bit unlock word into its control register. It then counts down from a programmable start value. Software must keep it alive by writing a two-word key pair to a key register. The pair is only honoured while the counter sits in the open window, which is a chosen fraction at the tail end of the countdown. A key pair completed before the window opens is a fault, and so is a countdown that reaches zero with no service. Both faults set a sticky status flag and drive either a reset request or a non-maskable interrupt request. Which of the two is driven depends on a reaction register.

The register port is a plain single-cycle bus: a write strobe with address and data, and a read strobe with a combinational read-data return. Because every access completes in its own cycle, the port has no valid/ready handshake and no back-pressure. The counting rate comes from a `tick` input, a one-cycle enable in the `clk` domain that is produced by a slow reference elsewhere. The counter advances only on cycles where `tick` is high. Once started, the timer cannot be stopped by software. Only `rst_n` returns it to the idle state.

Top module: `win_wdog`

## Requirements
- R1: The timer starts only when a bus write to offset 0x90 carries exactly 0xA98559DA. Any other value leaves it stopped. While stopped, the counter reads 0 and never changes.
- R2: Once started, the timer stays running until `rst_n` is asserted. Later writes to 0x90 are ignored. A read of 0x90 returns 1 in bit 0 while running and 0 otherwise.
- R3: The start value is the 12-bit field at offset 0x94, shifted left by `PRELOAD_SHIFT`. It is captured at start and again at every completed key pair. The counter is read at 0xA0. It drops by one on each cycle with `tick` high and holds when `tick` is low.
- R4: A key pair is 0xE51A followed, on the very next write to offset 0x9C, by 0xA35C. Any other key write returns the checker to idle without reloading the counter. A lone 0xA35C has no effect, and key writes have no effect while the timer is stopped.
- R5: The window code at offset 0xA8 selects the open window as follows. 0x50 opens it when the counter is at or below 1/2 of the captured start value, 0x500 at or below 1/4, and 0x5000 at or below 1/8. Every other code keeps the window always open.
- R6: A key pair completed while the window is open reloads the counter from the start value and raises no fault.
- R7: A key pair completed while the window is closed raises a fault. It also reloads the counter, so a new period begins.
- R8: A `tick` cycle with the counter at 0 raises a fault and reloads the counter from the captured start value.
- R9: A fault sets status bit 1 at offset 0x98. The bit stays set until software writes 1 to it, and all other status bits read 0. A fault in the same cycle as the clear wins.
- R10: While status bit 1 is set, `nmi_req` is high if the reaction register at 0xA4 holds 0xA. Otherwise `rst_req` is high. The two outputs are never high together.
- R11: The window code and the reaction register read back the full word last written to them. `bus_rdata` is 0 when `bus_re` is low and for unmapped offsets.
- R12: After reset the timer is stopped. Counter and status read 0, the start field reads 0xFFF, the window code reads 0x05, the reaction register reads 0x5, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the slow reference, one cycle per count |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero unless `bus_re` |
| rst_req | output | 1 | Reset request on fault |
| nmi_req | output | 1 | Non-maskable interrupt request on fault |

## Verification
Most internal faults in this timer show up at the counter register within one `tick`: a missed decrement, a wrong reload width or a reload taken from the wrong source. Window faults are harder to see, because a wrong threshold only changes the outcome of a key pair that lands near the boundary. The bench therefore places key pairs a few counts on each side of every threshold and reads status one cycle later. A stuck key-checker state appears only on the next key pair, so the broken-sequence case is followed at once by a counter read. That read shows whether a reload took place when it should not have.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

  // Register byte offsets (software decodes these)
  localparam logic [7:0] OFS_CTRL  = 8'h90;
  localparam logic [7:0] OFS_LOAD  = 8'h94;
  localparam logic [7:0] OFS_STAT  = 8'h98;
  localparam logic [7:0] OFS_KEY   = 8'h9C;
  localparam logic [7:0] OFS_COUNT = 8'hA0;
  localparam logic [7:0] OFS_REACT = 8'hA4;
  localparam logic [7:0] OFS_WIN   = 8'hA8;

  // Magic words
  localparam logic [31:0] START_WORD = 32'hA985_59DA;
  localparam logic [31:0] KEY_FIRST  = 32'h0000_E51A;
  localparam logic [31:0] KEY_SECOND = 32'h0000_A35C;

  // Reaction and window codes
  localparam logic [31:0] REACT_NMI    = 32'h0000_000A;
  localparam logic [31:0] REACT_RESET  = 32'h0000_0005;
  localparam logic [31:0] WIN_FULL     = 32'h0000_0005;
  localparam logic [31:0] WIN_HALF     = 32'h0000_0050;
  localparam logic [31:0] WIN_QUARTER  = 32'h0000_0500;
  localparam logic [31:0] WIN_EIGHTH   = 32'h0000_5000;

  // Number of window fractions: 1, 1/2, 1/4, 1/8
  localparam int WIN_STEPS = 4;

  typedef enum logic {
    KS_IDLE,
    KS_ARMED
  } keyseq_state_t;

endpackage

// File: rtl/win_wdog_regs.sv
module win_wdog_regs
  import win_wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 12,
  parameter int CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 viol_pulse,
  output logic                 enabled,
  output logic                 start_pulse,
  output logic                 key_wr,
  output logic [PRELOAD_W-1:0] preload,
  output logic [DATA_W-1:0]    win_code,
  output logic                 react_nmi,
  output logic                 viol_flag
);

  localparam logic [PRELOAD_W-1:0] PRELOAD_RST = '1;

  logic            sel_ctrl, sel_load, sel_stat, sel_key;
  logic            sel_count, sel_react, sel_win;
  logic [DATA_W-1:0] react_q;

  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_load  = (bus_addr == ADDR_W'(OFS_LOAD));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_key   = (bus_addr == ADDR_W'(OFS_KEY));
  assign sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
  assign sel_react = (bus_addr == ADDR_W'(OFS_REACT));
  assign sel_win   = (bus_addr == ADDR_W'(OFS_WIN));

  assign start_pulse = bus_we && sel_ctrl && !enabled &&
                       (bus_wdata == DATA_W'(START_WORD));
  assign key_wr      = bus_we && sel_key;
  assign react_nmi   = (react_q == DATA_W'(REACT_NMI));

  // Run state: set once by the unlock word, cleared only by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
    end else if (start_pulse) begin
      enabled <= 1'b1;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload  <= PRELOAD_RST;
      win_code <= DATA_W'(WIN_FULL);
      react_q  <= DATA_W'(REACT_RESET);
    end else if (bus_we) begin
      if (sel_load)  preload  <= bus_wdata[PRELOAD_W-1:0];
      if (sel_win)   win_code <= bus_wdata;
      if (sel_react) react_q  <= bus_wdata;
    end
  end

  // Sticky fault flag, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_flag <= 1'b0;
    end else if (viol_pulse) begin
      viol_flag <= 1'b1;
    end else if (bus_we && sel_stat && bus_wdata[1]) begin
      viol_flag <= 1'b0;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (sel_ctrl)       bus_rdata = DATA_W'(enabled);
      else if (sel_load)  bus_rdata = DATA_W'(preload);
      else if (sel_stat)  bus_rdata = DATA_W'({viol_flag, 1'b0});
      else if (sel_count) bus_rdata = DATA_W'(cnt);
      else if (sel_react) bus_rdata = react_q;
      else if (sel_win)   bus_rdata = win_code;
      else                bus_rdata = '0;
    end
  end

endmodule

// File: rtl/win_wdog_keyseq.sv
module win_wdog_keyseq
  import win_wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enabled,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              svc_done
);

  keyseq_state_t state_q, state_d;
  logic          is_first, is_second;

  assign is_first  = (key_data == DATA_W'(KEY_FIRST));
  assign is_second = (key_data == DATA_W'(KEY_SECOND));

  always_comb begin
    state_d  = state_q;
    svc_done = 1'b0;
    if (!enabled) begin
      state_d = KS_IDLE;
    end else if (key_wr) begin
      unique case (state_q)
        KS_IDLE: begin
          state_d = is_first ? KS_ARMED : KS_IDLE;
        end
        KS_ARMED: begin
          if (is_second) begin
            svc_done = 1'b1;
            state_d  = KS_IDLE;
          end else if (is_first) begin
            state_d = KS_ARMED;
          end else begin
            state_d = KS_IDLE;
          end
        end
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/win_wdog_count.sv
module win_wdog_count
  import win_wdog_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13,
  parameter int CNT_W         = PRELOAD_W + PRELOAD_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 enabled,
  input  logic                 start_pulse,
  input  logic                 svc_done,
  input  logic [PRELOAD_W-1:0] preload,
  input  logic [DATA_W-1:0]    win_code,
  output logic [CNT_W-1:0]     cnt,
  output logic                 win_open,
  output logic                 viol_pulse
);

  localparam int SEL_W = $clog2(WIN_STEPS);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] fresh;
  logic [CNT_W-1:0] thr [WIN_STEPS];
  logic [SEL_W-1:0] win_sel;
  logic             expire;

  assign fresh = {preload, {PRELOAD_SHIFT{1'b0}}};

  // One threshold per window fraction: start value >> step
  for (genvar g = 0; g < WIN_STEPS; g++) begin : g_thr
    assign thr[g] = reload_q >> g;
  end

  always_comb begin
    if (win_code == DATA_W'(WIN_HALF))         win_sel = SEL_W'(1);
    else if (win_code == DATA_W'(WIN_QUARTER)) win_sel = SEL_W'(2);
    else if (win_code == DATA_W'(WIN_EIGHTH))  win_sel = SEL_W'(3);
    else                                       win_sel = SEL_W'(0);
  end

  assign win_open   = (cnt <= thr[win_sel]);
  assign expire     = enabled && tick && (cnt == '0) && !svc_done;
  assign viol_pulse = expire || (svc_done && !win_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      reload_q <= '0;
    end else if (start_pulse || svc_done) begin
      cnt      <= fresh;
      reload_q <= fresh;
    end else if (enabled && tick) begin
      if (cnt == '0) cnt <= reload_q;
      else           cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              nmi_req
);

  localparam int CNT_W = PRELOAD_W + PRELOAD_SHIFT;

  logic                 enabled, start_pulse, key_wr, svc_done;
  logic                 react_nmi, viol_flag, viol_pulse, win_open;
  logic [PRELOAD_W-1:0] preload;
  logic [DATA_W-1:0]    win_code;
  logic [CNT_W-1:0]     cnt;

  win_wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .viol_pulse(viol_pulse),
    .enabled(enabled), .start_pulse(start_pulse), .key_wr(key_wr),
    .preload(preload), .win_code(win_code), .react_nmi(react_nmi),
    .viol_flag(viol_flag)
  );

  win_wdog_keyseq #(.DATA_W(DATA_W)) u_keyseq (
    .clk(clk), .rst_n(rst_n), .enabled(enabled),
    .key_wr(key_wr), .key_data(bus_wdata), .svc_done(svc_done)
  );

  win_wdog_count #(
    .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W),
    .PRELOAD_SHIFT(PRELOAD_SHIFT), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enabled(enabled),
    .start_pulse(start_pulse), .svc_done(svc_done), .preload(preload),
    .win_code(win_code), .cnt(cnt), .win_open(win_open),
    .viol_pulse(viol_pulse)
  );

  assign nmi_req = viol_flag && react_nmi;
  assign rst_req = viol_flag && !react_nmi;

endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_bit,
  input logic              enabled,
  input logic              svc_done,
  input logic [CNT_W-1:0]  cnt,
  input logic              viol_flag,
  input logic              rst_req,
  input logic              nmi_req
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h98);

  // R2: running state never drops without reset
  a_r2_stays_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> enabled);

  // R1: counter idle at zero while stopped
  a_r1_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (cnt == '0));

  // R3: one count per tick when no service and not at zero
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && tick && (cnt != '0) && !svc_done) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R8: tick at zero without service raises the flag
  a_r8_expiry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && tick && (cnt == '0) && !svc_done) |=> viol_flag);

  // R9: flag stays set unless cleared by a write of 1 to bit 1 of status
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !(bus_we && (bus_addr == STAT_ADDR) && clr_bit)) |=> viol_flag);

  // R10: at most one reaction output
  a_r10_one_reaction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, nmi_req}));

  // R10: a request is present exactly while the flag is set
  a_r10_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag == (rst_req || nmi_req));

endmodule

bind win_wdog win_wdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
  .bus_addr(bus_addr), .clr_bit(bus_wdata[1]), .enabled(enabled),
  .svc_done(svc_done), .cnt(cnt), .viol_flag(viol_flag),
  .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/tb_win_wdog.sv
`timescale 1ns/1ps
module tb_win_wdog;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SHIFT  = 4;

  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_WT = 2'd2;
  localparam int NV = 62;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic bus_we = 1'b0;
  logic bus_re = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic rst_req, nmi_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  win_wdog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(12), .PRELOAD_SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  // {op, addr, data, expected, requirement number}; start value 0x10<<4 = 256
  localparam logic [77:0] VEC [NV] = '{
    {OP_RD, 8'h90, 32'h0, 32'h0, 4'd1},        // R1 stopped
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd12},       // R12
    {OP_RD, 8'hA0, 32'h0, 32'h0, 4'd12},       // R12
    {OP_RD, 8'h94, 32'h0, 32'hFFF, 4'd12},     // R12
    {OP_RD, 8'hA8, 32'h0, 32'h5, 4'd12},       // R12
    {OP_RD, 8'hA4, 32'h0, 32'h5, 4'd12},       // R12
    {OP_WR, 8'h94, 32'h10, 32'h0, 4'd0},
    {OP_WR, 8'h90, 32'h12345678, 32'h0, 4'd0},
    {OP_RD, 8'h90, 32'h0, 32'h0, 4'd1},        // R1 wrong word
    {OP_RD, 8'hA0, 32'h0, 32'h0, 4'd1},        // R1
    {OP_WR, 8'hA8, 32'h50, 32'h0, 4'd0},
    {OP_WR, 8'h90, 32'hA98559DA, 32'h0, 4'd0}, // cnt 256
    {OP_RD, 8'h90, 32'h0, 32'h1, 4'd2},        // R2
    {OP_RD, 8'hA0, 32'h0, 32'd255, 4'd3},      // R3
    {OP_WR, 8'h90, 32'h0, 32'h0, 4'd0},
    {OP_RD, 8'h90, 32'h0, 32'h1, 4'd2},        // R2 no stop
    {OP_RD, 8'hA0, 32'h0, 32'd252, 4'd3},      // R3
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // at 250 > 128: early
    {OP_RD, 8'h98, 32'h0, 32'h2, 4'd7},        // R7
    {OP_RD, 8'hA0, 32'h0, 32'd255, 4'd7},      // R7 reloaded
    {OP_WR, 8'h98, 32'h2, 32'h0, 4'd0},
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd9},        // R9 cleared
    {OP_WT, 8'h00, 32'd124, 32'h0, 4'd0},
    {OP_RD, 8'hA0, 32'h0, 32'd128, 4'd5},      // R5
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // at 126: open
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd6},        // R6
    {OP_RD, 8'hA0, 32'h0, 32'd255, 4'd6},      // R6
    {OP_WR, 8'h94, 32'h8, 32'h0, 4'd0},
    {OP_WT, 8'h00, 32'd130, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'h1234, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},
    {OP_RD, 8'hA0, 32'h0, 32'd120, 4'd4},      // R4 no reload
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd4},        // R4
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // new start 128
    {OP_RD, 8'hA0, 32'h0, 32'd128, 4'd3},      // R3 recaptured
    {OP_WT, 8'h00, 32'd127, 32'h0, 4'd0},
    {OP_RD, 8'hA0, 32'h0, 32'd0, 4'd8},        // R8
    {OP_RD, 8'h98, 32'h0, 32'h2, 4'd8},        // R8 expired
    {OP_RD, 8'hA0, 32'h0, 32'd127, 4'd8},      // R8 reloaded
    {OP_WR, 8'h98, 32'h2, 32'h0, 4'd0},
    {OP_WR, 8'hA8, 32'h500, 32'h0, 4'd0},
    {OP_WT, 8'h00, 32'd80, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // at 43 > 32: early
    {OP_RD, 8'h98, 32'h0, 32'h2, 4'd5},        // R5 quarter
    {OP_WR, 8'h98, 32'h2, 32'h0, 4'd0},
    {OP_RD, 8'hA8, 32'h0, 32'h500, 4'd11},     // R11
    {OP_WR, 8'hA8, 32'h5000, 32'h0, 4'd0},
    {OP_WT, 8'h00, 32'd107, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // at 16 <= 16: open
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd5},        // R5 eighth
    {OP_RD, 8'hA0, 32'h0, 32'd127, 4'd5},      // R5
    {OP_WR, 8'hA8, 32'h77, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hE51A, 32'h0, 4'd0},
    {OP_WR, 8'h9C, 32'hA35C, 32'h0, 4'd0},     // unknown code: open
    {OP_RD, 8'h98, 32'h0, 32'h0, 4'd5},        // R5 other code
    {OP_RD, 8'hA0, 32'h0, 32'd127, 4'd6}       // R6
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input int req);
    logic [31:0] v;
    bus_addr = a; bus_re = 1'b1;
    #1;
    v = bus_rdata;
    bus_re = 1'b0;
    chk(req, v, exp);
    @(negedge clk);
  endtask

  task automatic ports(input logic r, input logic n, input int req);
    #1;
    chk(req, {31'b0, rst_req}, {31'b0, r});
    chk(req, {31'b0, nmi_req}, {31'b0, n});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ports(1'b0, 1'b0, 12); // R12 outputs low
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][77:76])
        OP_RD: do_rd(VEC[i][75:68], VEC[i][35:4], int'(VEC[i][3:0]));
        OP_WR: do_wr(VEC[i][75:68], VEC[i][67:36]);
        default: repeat (int'(VEC[i][67:36])) @(negedge clk);
      endcase
    end

    // R10 default reaction is reset request
    repeat (140) @(negedge clk);
    ports(1'b1, 1'b0, 10);
    @(negedge clk);
    do_rd(8'h98, 32'h2, 9);
    do_wr(8'h98, 32'h2);
    ports(1'b0, 1'b0, 9); // R9 clear drops request
    @(negedge clk);
    do_wr(8'hA4, 32'hA);
    do_rd(8'hA4, 32'hA, 11); // R11
    repeat (140) @(negedge clk);
    ports(1'b0, 1'b1, 10); // R10 interrupt selected
    @(negedge clk);

    // R3 hold while tick low
    tick = 1'b0;
    bus_addr = 8'hA0; bus_re = 1'b1; #1; a0 = bus_rdata; bus_re = 1'b0;
    @(negedge clk);
    repeat (10) @(negedge clk);
    do_rd(8'hA0, a0, 3);

    // R12 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ports(1'b0, 1'b0, 12);
    @(negedge clk);
    do_rd(8'h90, 32'h0, 12);
    do_rd(8'hA0, 32'h0, 12);
    do_rd(8'hA4, 32'h5, 12);
    tick = 1'b1;

    // R4 keys ignored while stopped
    do_wr(8'h9C, 32'hE51A);
    do_wr(8'h9C, 32'hA35C);
    do_rd(8'h98, 32'h0, 4);
    do_rd(8'hA0, 32'h0, 4);

    // R11 no read strobe gives zero
    bus_addr = 8'h94; bus_re = 1'b0; #1;
    chk(11, bus_rdata, 32'h0);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule